// File: doc/BRIEF.md
# Conditional-Sum Adder with Select Tree

This block adds two unsigned operands and a carry-in, then registers the sum and the carry-out. The width is split into a low segment of its own width, which is a plain ripple adder, and a row of equal-width upper groups. Each upper group computes two candidate results side by side: one that assumes its incoming carry is 0 and one that assumes it is 1.

The carry-out pairs of the upper groups feed a logarithmic prefix tree. At each level the span of groups that a select pair covers doubles. After the last level, each group holds a pair that tells what carry enters it for either value of the low segment's carry. The low segment's carry reaches every final multiplexer through its own fan-out tree. Each group's sum is then picked once, with no group-to-group chain.

Results appear on the outputs one clock after the operands are presented. Width, upper group width and low segment width are parameters. The width less the low segment width must be a whole multiple of the group width.

Top module: `csum_adder`

## Requirements
- R1: One clock edge after operands a_i, b_i and carry-in cin_i are sampled, sum_o equals (a_i + b_i + cin_i) modulo 2^WIDTH_P.
- R2: At the same edge, cout_o equals bit WIDTH_P of the full unsigned sum a_i + b_i + cin_i.
- R3: While rst_ni is low, sum_o and cout_o are held at zero.
- R4: With a_i all ones, b_i zero and cin_i one, the carry-in ripples through every group: sum_o is zero and cout_o is one.
- R5: For fixed a_i and b_i, raising cin_i from 0 to 1 raises the registered {cout_o, sum_o} by exactly one.
- R6: A carry made inside the low segment reaches every upper group and the carry-out with one value: a_i all ones, b_i one and cin_i zero give sum_o zero and cout_o one. Every copy of the low segment carry carries that same value.
- R7: The result is correct for any group split, including a single upper group and a one-bit low segment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | WIDTH_P | First addend |
| b_i | input | WIDTH_P | Second addend |
| cin_i | input | 1 | Carry-in |
| sum_o | output | WIDTH_P | Registered sum |
| cout_o | output | 1 | Registered carry-out |

## Verification
The bench builds three copies side by side.
- A 32-bit adder with 4-bit groups over an 8-bit low segment: six upper groups, so the select tree runs three levels with a non-power-of-two group count.
- A 16-bit adder with 5-bit groups over a 1-bit low segment: three groups, with a low segment of a single bit.
- A 12-bit adder with one 8-bit group over a 4-bit low segment: the tree collapses to zero levels.

All three take the same stimulus: corner operands that force a carry through every group, carry-in toggles on fixed operands, and random pairs.

// File: rtl/csum_pkg.sv
package csum_pkg;

  typedef struct packed {
    logic c1;
    logic c0;
  } cpair_t;

  // hi spans upper groups, lo spans the groups below it
  function automatic cpair_t csum_merge(cpair_t lo, cpair_t hi);
    cpair_t r;
    r.c0 = lo.c0 ? hi.c1 : hi.c0;
    r.c1 = lo.c1 ? hi.c1 : hi.c0;
    return r;
  endfunction

endpackage

// File: rtl/csum_ripple.sv
module csum_ripple #(
  parameter int W_P = 4
) (
  input  logic [W_P-1:0] a_i,
  input  logic [W_P-1:0] b_i,
  input  logic           cin_i,
  output logic [W_P-1:0] sum_o,
  output logic           cout_o
);
  logic [W_P:0] c_w;

  assign c_w[0] = cin_i;

  for (genvar k = 0; k < W_P; k++) begin : g_fa
    assign sum_o[k]  = a_i[k] ^ b_i[k] ^ c_w[k];
    assign c_w[k+1]  = (a_i[k] & b_i[k]) | (c_w[k] & (a_i[k] ^ b_i[k]));
  end

  assign cout_o = c_w[W_P];
endmodule

// File: rtl/csum_cand.sv
module csum_cand #(
  parameter int W_P = 4
) (
  input  logic [W_P-1:0] a_i,
  input  logic [W_P-1:0] b_i,
  output logic [W_P-1:0] s0_o,
  output logic [W_P-1:0] s1_o,
  output logic           c0_o,
  output logic           c1_o
);
  csum_ripple #(.W_P(W_P)) u_z (
    .a_i(a_i), .b_i(b_i), .cin_i(1'b0), .sum_o(s0_o), .cout_o(c0_o)
  );
  csum_ripple #(.W_P(W_P)) u_o (
    .a_i(a_i), .b_i(b_i), .cin_i(1'b1), .sum_o(s1_o), .cout_o(c1_o)
  );
endmodule

// File: rtl/csum_fanout.sv
module csum_fanout #(
  parameter int COPIES_P = 4
) (
  input  logic                d_i,
  output logic [COPIES_P-1:0] q_o
);
  localparam int LV = (COPIES_P > 1) ? $clog2(COPIES_P) : 0;

  for (genvar k = 0; k <= LV; k++) begin : g_lvl
    localparam int WK = (COPIES_P + (1 << (LV - k)) - 1) >> (LV - k);
    logic [WK-1:0] n_w;
    if (k == 0) begin : g_root
      assign n_w[0] = d_i;
    end else begin : g_node
      for (genvar j = 0; j < WK; j++) begin : g_j
        assign n_w[j] = g_lvl[k-1].n_w[j/2];
      end
    end
  end

  assign q_o = g_lvl[LV].n_w;
endmodule

// File: rtl/csum_sel_tree.sv
module csum_sel_tree
  import csum_pkg::*;
#(
  parameter int NG_P = 6
) (
  input  logic [NG_P-1:0] c0_i,
  input  logic [NG_P-1:0] c1_i,
  output logic [NG_P-1:0] e0_o,
  output logic [NG_P-1:0] e1_o
);
  localparam int LV = (NG_P > 1) ? $clog2(NG_P) : 0;

  cpair_t lvl [LV+1][NG_P];

  always_comb begin
    for (int i = 0; i < NG_P; i++) begin
      lvl[0][i].c0 = c0_i[i];
      lvl[0][i].c1 = c1_i[i];
    end
    for (int k = 0; k < LV; k++) begin
      for (int i = 0; i < NG_P; i++) begin
        if (i >= (1 << k)) lvl[k+1][i] = csum_merge(lvl[k][i-(1<<k)], lvl[k][i]);
        else               lvl[k+1][i] = lvl[k][i];
      end
    end
    for (int i = 0; i < NG_P; i++) begin
      e0_o[i] = lvl[LV][i].c0;
      e1_o[i] = lvl[LV][i].c1;
    end
  end
endmodule

// File: rtl/csum_adder.sv
module csum_adder #(
  parameter int WIDTH_P = 32,
  parameter int GRP_P   = 4,
  parameter int LOW_P   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH_P-1:0] a_i,
  input  logic [WIDTH_P-1:0] b_i,
  input  logic               cin_i,
  output logic [WIDTH_P-1:0] sum_o,
  output logic               cout_o
);
  localparam int NUP = (WIDTH_P - LOW_P) / GRP_P;

  logic [LOW_P-1:0] low_sum_w;
  logic             low_c_w;
  logic [NUP:0]     fan_w;
  logic [NUP-1:0]   c0_w, c1_w, e0_w, e1_w;
  wire  [NUP-1:0]   gcin_w;
  wire  [WIDTH_P-1:0] sum_d;
  logic             cout_d;

  csum_ripple #(.W_P(LOW_P)) u_low (
    .a_i(a_i[LOW_P-1:0]), .b_i(b_i[LOW_P-1:0]), .cin_i(cin_i),
    .sum_o(low_sum_w), .cout_o(low_c_w)
  );

  csum_fanout #(.COPIES_P(NUP+1)) u_fan (.d_i(low_c_w), .q_o(fan_w));

  assign sum_d[LOW_P-1:0] = low_sum_w;

  for (genvar i = 0; i < NUP; i++) begin : g_up
    localparam int BASE = LOW_P + i * GRP_P;
    logic [GRP_P-1:0] s0_w, s1_w;

    csum_cand #(.W_P(GRP_P)) u_cand (
      .a_i(a_i[BASE +: GRP_P]), .b_i(b_i[BASE +: GRP_P]),
      .s0_o(s0_w), .s1_o(s1_w), .c0_o(c0_w[i]), .c1_o(c1_w[i])
    );

    if (i == 0) begin : g_first
      assign gcin_w[i] = fan_w[i];
    end else begin : g_rest
      assign gcin_w[i] = fan_w[i] ? e1_w[i-1] : e0_w[i-1];
    end

    assign sum_d[BASE +: GRP_P] = gcin_w[i] ? s1_w : s0_w;
  end

  csum_sel_tree #(.NG_P(NUP)) u_tree (
    .c0_i(c0_w), .c1_i(c1_w), .e0_o(e0_w), .e1_o(e1_w)
  );

  assign cout_d = fan_w[NUP] ? e1_w[NUP-1] : e0_w[NUP-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_d;
      cout_o <= cout_d;
    end
  end
endmodule

// File: rtl/csum_adder_chk.sv
module csum_adder_chk #(
  parameter int WIDTH_P  = 32,
  parameter int COPIES_P = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [WIDTH_P-1:0] a_i,
  input logic [WIDTH_P-1:0] b_i,
  input logic               cin_i,
  input logic [WIDTH_P-1:0] sum_o,
  input logic               cout_o,
  input logic [COPIES_P-1:0] fan_i
);
  logic [1:0]       warm_q;
  logic [WIDTH_P:0] ref_q;
  logic             ones_q, gen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q <= '0;
      ref_q  <= '0;
      ones_q <= 1'b0;
      gen_q  <= 1'b0;
    end else begin
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      ref_q  <= {1'b0, a_i} + {1'b0, b_i} + {{WIDTH_P{1'b0}}, cin_i};
      ones_q <= (&a_i) && (b_i == '0) && cin_i;
      gen_q  <= (&a_i) && (b_i == {{(WIDTH_P-1){1'b0}}, 1'b1}) && !cin_i;
    end
  end

  a_r1_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0) |-> (sum_o == ref_q[WIDTH_P-1:0]));

  a_r2_cout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0) |-> (cout_o == ref_q[WIDTH_P]));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r3_reset_zero: assert (sum_o == '0 && !cout_o);
    end
  end

  a_r4_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0 && ones_q) |-> (sum_o == '0 && cout_o));

  a_r5_cin_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && $past(a_i) == $past(a_i, 2) && $past(b_i) == $past(b_i, 2)
     && $past(cin_i) && !$past(cin_i, 2))
    |-> ({cout_o, sum_o} == $past({cout_o, sum_o}) + 1'b1));

  a_r6_low_gen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0 && gen_q) |-> (sum_o == '0 && cout_o));

  a_r6_fan_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fan_i == '0) || (fan_i == '1));
endmodule

bind csum_adder csum_adder_chk #(.WIDTH_P(WIDTH_P), .COPIES_P(NUP+1)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
  .sum_o(sum_o), .cout_o(cout_o), .fan_i(fan_w)
);

// File: tb/csum_adder_tb.sv
module csum_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a_d = '0, b_d = '0;
  logic        cin_d = 1'b0;

  logic [31:0] s32; logic c32;
  logic [15:0] s16; logic c16;
  logic [11:0] s12; logic c12;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [32:0] e32;
    logic [16:0] e16;
    logic [12:0] e12;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #2.5 clk = ~clk;

  // six upper groups, three tree levels
  csum_adder #(.WIDTH_P(32), .GRP_P(4), .LOW_P(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_d), .b_i(b_d), .cin_i(cin_d),
    .sum_o(s32), .cout_o(c32));
  // one-bit low segment
  csum_adder #(.WIDTH_P(16), .GRP_P(5), .LOW_P(1)) dut_b (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_d[15:0]), .b_i(b_d[15:0]), .cin_i(cin_d),
    .sum_o(s16), .cout_o(c16));
  // single upper group, no tree level
  csum_adder #(.WIDTH_P(12), .GRP_P(8), .LOW_P(4)) dut_c (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_d[11:0]), .b_i(b_d[11:0]), .cin_i(cin_d),
    .sum_o(s12), .cout_o(c12));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic c,
                       input string tag);
    item_t it;
    @(negedge clk);
    a_d = a; b_d = b; cin_d = c;
    it.e32 = {1'b0, a} + {1'b0, b} + {32'd0, c};
    it.e16 = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'd0, c};
    it.e12 = {1'b0, a[11:0]} + {1'b0, b[11:0]} + {12'd0, c};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: sample 1 ns after the capturing edge
  always begin
    @(posedge clk);
    #1;
    if (rst_ni && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks += 3;
      if ({c32, s32} !== it.e32) begin
        fails++;
        $display("FAIL %s R7 w32: actual %h expected %h", it.tag, {c32, s32}, it.e32);
      end
      if ({c16, s16} !== it.e16) begin
        fails++;
        $display("FAIL %s R7 w16: actual %h expected %h", it.tag, {c16, s16}, it.e16);
      end
      if ({c12, s12} !== it.e12) begin
        fails++;
        $display("FAIL %s R7 w12: actual %h expected %h", it.tag, {c12, s12}, it.e12);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual cycles 100000 expected fewer");
    summary();
    $finish;
  end

  initial begin
    // R3: reset state, with inputs nonzero
    a_d = 32'hFFFF_FFFF; b_d = 32'h1234_5678; cin_d = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({c32, s32, c16, s16, c12, s12} !== '0) begin
      fails++;
      $display("FAIL R3 reset: actual %h_%h_%h expected 0", {c32, s32}, {c16, s16}, {c12, s12});
    end
    @(negedge clk);
    a_d = '0; b_d = '0; cin_d = 1'b0;
    rst_ni = 1'b1;

    drive(32'h0, 32'h0, 1'b0, "R1");
    drive(32'hFFFF_FFFF, 32'h0, 1'b1, "R4");
    drive(32'hFFFF_FFFF, 32'h1, 1'b0, "R6");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R2");
    drive(32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0, "R5");
    drive(32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b1, "R5");
    drive(32'h0000_00FF, 32'h0000_0001, 1'b0, "R6");
    drive(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "R5");
    drive(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R5");
    for (int n = 0; n < 400; n++) begin
      drive($urandom, $urandom, 1'($urandom), "R1");
    end
    repeat (3) @(posedge clk);
    #2;

    // R3: asynchronous reset mid-run clears outputs
    rst_ni = 1'b0;
    #1;
    checks++;
    if ({c32, s32, c16, s16, c12, s12} !== '0) begin
      fails++;
      $display("FAIL R3 midrun: actual %h_%h_%h expected 0", {c32, s32}, {c16, s16}, {c12, s12});
    end
    summary();
    $finish;
  end
endmodule